// File: doc/BRIEF.md
# Per-Port Statistics Snapshot Unit

This block keeps a bank of free-running event counters for every port of a switch. Each counter advances by one in every clock cycle in which its own event input is high. The host cannot read the live counters directly. It first orders a snapshot of one port, which freezes all of that port's counters into a single capture bank in the same clock cycle. It then reads the frozen counters one at a time. Counters that are read one after another therefore all belong to the same instant, while the live counters keep counting.

The host sees a 16-bit register window with three registers:

| Address | Register | Access |
|---|---|---|
| 0 | Command and busy | write commands, read busy |
| 1 | Data high | read only |
| 2 | Data low | read only |

A 32-bit captured value is returned as two 16-bit halves. A 64-bit statistic is kept by convention as two consecutive counters: the low word at index n and the high word at index n+1. Both words come from the same snapshot, so the host can join them safely. Every command completes one clock cycle after it is accepted, which is well inside any short polling budget.

Top module: `stats_snap_top`

## Requirements
- R1: A synchronous active-high reset clears every live counter and every captured counter, clears the busy flag, and sets both data registers to zero.
- R2: A live counter adds one at each clock edge where its event bit is high. Event bit p*NUM_CNT+c belongs to counter c of port p. The counter wraps modulo 2^CNT_W, where CNT_W is 32 by default.
- R3: Reading address 0 returns the busy flag in bit 15 and zeros in bits 14:0. Reading address 3 returns zero. An accepted command sets busy in the cycle after its write edge. Busy clears at the next edge, when the command takes effect.
- R4: Writing 0xDC00 | p to address 0 captures all NUM_CNT live counters of port p (p in bits 7:0) into the capture bank. Each captured value is the live value before the edge at which busy clears, so an increment that lands in the busy cycle reaches the live counter but not the capture. A port number of NUM_PORTS or higher leaves the capture bank unchanged.
- R5: Writing 0xCC00 | i to address 0 loads captured counter i (i in bits 7:0) into the data registers at the edge where busy clears. Bits 31:16 go to address 1 and bits 15:0 go to address 2, zero-extended from CNT_W bits. The data registers otherwise hold their value.
- R6: A read command with an index of NUM_CNT or higher sets both data registers to zero.
- R7: The capture bank changes only on a snapshot, so repeated reads and reads of the two indices of a 64-bit pair return values from the same snapshot while the live counters keep counting.
- R8: The following writes have no effect on busy, the capture bank or the data registers:
  - a write while busy is set;
  - a write to address 0 whose upper byte is neither 0xDC nor 0xCC;
  - any write to addresses 1 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostWr | input | 1 | Register write strobe |
| hostAddr | input | 2 | Register address (0 command, 1 data high, 2 data low) |
| hostWrData | input | 16 | Register write data |
| hostRdData | output | 16 | Register read data for hostAddr, combinational |
| evtInc | input | NUM_PORTS*NUM_CNT | Per-counter event bits, one per counter |

## Verification
The bench builds the block with NUM_PORTS=3, NUM_CNT=5 and CNT_W=12. The 12-bit width lets the bench drive a counter past its wrap point in about four thousand cycles. Three ports leave port numbers 3 to 255 free to test the out-of-range snapshot case. Five counters per port leave indices 5 to 255 free to test the zero readout, and they give room for a 64-bit pair at indices 3 and 4. A behavioural model runs the same register window, and in the random-event phase it shows the frozen bank staying put while every live counter moves.

// File: rtl/stats_snap_pkg.sv
`timescale 1ns/1ps
package stats_snap_pkg;
  localparam logic [7:0] OP_SNAP = 8'hDC;
  localparam logic [7:0] OP_READ = 8'hCC;
  localparam logic [1:0] A_CMD   = 2'd0;
  localparam logic [1:0] A_HI    = 2'd1;
  localparam logic [1:0] A_LO    = 2'd2;

  typedef struct packed {
    logic       snap;
    logic       rd;
    logic [7:0] arg;
  } snapStrb_t;
endpackage

// File: rtl/stats_snap_ctrl.sv
`timescale 1ns/1ps
module stats_snap_ctrl
  import stats_snap_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        hostWr,
  input  logic [1:0]  hostAddr,
  input  logic [15:0] hostWrData,
  output logic        busy,
  output snapStrb_t   strb
);
  logic       pendSnap;
  logic [7:0] pendArg;
  logic       cmdHit;
  logic       isSnap;
  logic       isRead;

  assign cmdHit = hostWr && (hostAddr == A_CMD) && !busy;
  assign isSnap = hostWrData[15:8] == OP_SNAP;
  assign isRead = hostWrData[15:8] == OP_READ;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      pendSnap <= 1'b0;
      pendArg  <= '0;
    end else if (busy) begin
      busy <= 1'b0;
    end else if (cmdHit && (isSnap || isRead)) begin
      busy     <= 1'b1;
      pendSnap <= isSnap;
      pendArg  <= hostWrData[7:0];
    end
  end

  always_comb begin
    strb.snap = busy && pendSnap;
    strb.rd   = busy && !pendSnap;
    strb.arg  = pendArg;
  end
endmodule

// File: rtl/stats_snap_datapath.sv
`timescale 1ns/1ps
module stats_snap_datapath
  import stats_snap_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_CNT   = 8,
  parameter int CNT_W     = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_PORTS*NUM_CNT-1:0]  evtInc,
  input  snapStrb_t                     strb,
  output logic [15:0]                   dataHi,
  output logic [15:0]                   dataLo
);
  localparam int         PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int         IDX_W    = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
  localparam logic [7:0] PORT_LIM = 8'(NUM_PORTS);
  localparam logic [7:0] IDX_LIM  = 8'(NUM_CNT);

  typedef logic [NUM_CNT-1:0][CNT_W-1:0] bank_t;

  bank_t      livePort [NUM_PORTS];
  bank_t      capBank;
  logic [31:0] rdWord;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    bank_t cntQ;
    always_ff @(posedge clk) begin
      if (rst) begin
        cntQ <= '0;
      end else begin
        for (int c = 0; c < NUM_CNT; c++) begin
          cntQ[c] <= cntQ[c] + {{(CNT_W-1){1'b0}}, evtInc[p*NUM_CNT+c]};
        end
      end
    end
    assign livePort[p] = cntQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      capBank <= '0;
    end else if (strb.snap && (strb.arg < PORT_LIM)) begin
      capBank <= livePort[strb.arg[PORT_W-1:0]];
    end
  end

  assign rdWord = (strb.arg < IDX_LIM) ? 32'(capBank[strb.arg[IDX_W-1:0]]) : 32'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dataHi <= '0;
      dataLo <= '0;
    end else if (strb.rd) begin
      dataHi <= rdWord[31:16];
      dataLo <= rdWord[15:0];
    end
  end
endmodule

// File: rtl/stats_snap_top.sv
`timescale 1ns/1ps
module stats_snap_top
  import stats_snap_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_CNT   = 8,
  parameter int CNT_W     = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          hostWr,
  input  logic [1:0]                    hostAddr,
  input  logic [15:0]                   hostWrData,
  output logic [15:0]                   hostRdData,
  input  logic [NUM_PORTS*NUM_CNT-1:0]  evtInc
);
  logic        busy;
  snapStrb_t   strb;
  logic [15:0] dataHi;
  logic [15:0] dataLo;

  stats_snap_ctrl i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .hostWr     (hostWr),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .busy       (busy),
    .strb       (strb)
  );

  stats_snap_datapath #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_CNT   (NUM_CNT),
    .CNT_W     (CNT_W)
  ) i_dp (
    .clk    (clk),
    .rst    (rst),
    .evtInc (evtInc),
    .strb   (strb),
    .dataHi (dataHi),
    .dataLo (dataLo)
  );

  always_comb begin
    case (hostAddr)
      A_CMD:   hostRdData = {busy, 15'd0};
      A_HI:    hostRdData = dataHi;
      A_LO:    hostRdData = dataLo;
      default: hostRdData = 16'd0;
    endcase
  end
endmodule

// File: rtl/stats_snap_chk.sv
`timescale 1ns/1ps
module stats_snap_chk
  import stats_snap_pkg::*;
#(
  parameter int NUM_CNT = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        hostWr,
  input logic [1:0]  hostAddr,
  input logic [15:0] hostWrData,
  input logic        busy,
  input snapStrb_t   strb,
  input logic [15:0] dataHi,
  input logic [15:0] dataLo
);
  localparam logic [7:0] IDX_LIM = 8'(NUM_CNT);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!busy && dataHi == 16'd0 && dataLo == 16'd0));

  // R3
  busy_single_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);

  // R3
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && hostWr && hostAddr == A_CMD &&
     (hostWrData[15:8] == OP_SNAP || hostWrData[15:8] == OP_READ)) |=> busy);

  // R8
  bad_op_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(hostWr && hostAddr == A_CMD &&
     (hostWrData[15:8] == OP_SNAP || hostWrData[15:8] == OP_READ))) |=> !busy);

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.rd |=> ($stable(dataHi) && $stable(dataLo)));

  // R6
  range_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.rd && strb.arg >= IDX_LIM) |=> (dataHi == 16'd0 && dataLo == 16'd0));
endmodule

bind stats_snap_top stats_snap_chk #(.NUM_CNT(NUM_CNT)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .hostWr     (hostWr),
  .hostAddr   (hostAddr),
  .hostWrData (hostWrData),
  .busy       (busy),
  .strb       (strb),
  .dataHi     (dataHi),
  .dataLo     (dataLo)
);

// File: tb/test_stats_snap_top.sv
`timescale 1ns/1ps
module test_stats_snap_top;
  localparam int P  = 3;
  localparam int C  = 5;
  localparam int W  = 12;
  localparam int EW = P * C;
  localparam int unsigned MASK = (1 << W) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hostWr = 1'b0;
  logic [1:0]    hostAddr = 2'd0;
  logic [15:0]   hostWrData = 16'd0;
  logic [15:0]   hostRdData;
  logic [EW-1:0] evtInc = '0;

  int  errors = 0;
  int  checks = 0;
  bit  done = 0;
  bit  randOn = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  stats_snap_top #(.NUM_PORTS(P), .NUM_CNT(C), .CNT_W(W)) i_stats_snap_top (
    .clk(clk), .rst(rst), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .evtInc(evtInc)
  );

  // behavioural reference model
  int unsigned mLive [P][C];
  int unsigned mCap [C];
  bit          mBusy;
  bit          mSnap;
  int          mArg;
  int unsigned mHi, mLo;

  always @(posedge clk) begin
    if (rst) begin
      foreach (mLive[p, c]) mLive[p][c] = 0;
      foreach (mCap[c]) mCap[c] = 0;
      mBusy = 0; mSnap = 0; mArg = 0; mHi = 0; mLo = 0;
    end else begin
      if (mBusy) begin
        if (mSnap) begin
          if (mArg < P) foreach (mCap[c]) mCap[c] = mLive[mArg][c];
        end else if (mArg < C) begin
          mHi = (mCap[mArg] >> 16) & 16'hFFFF;
          mLo = mCap[mArg] & 16'hFFFF;
        end else begin
          mHi = 0; mLo = 0;
        end
        mBusy = 0;
      end else if (hostWr && hostAddr == 2'd0 &&
                   (hostWrData[15:8] == 8'hDC || hostWrData[15:8] == 8'hCC)) begin
        mBusy = 1;
        mSnap = (hostWrData[15:8] == 8'hDC);
        mArg  = int'(hostWrData[7:0]);
      end
      foreach (mLive[p, c]) if (evtInc[p*C+c]) mLive[p][c] = (mLive[p][c] + 1) & MASK;
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [15:0] e;
      case (hostAddr)
        2'd0: e = {mBusy, 15'd0};
        2'd1: e = 16'(mHi);
        2'd2: e = 16'(mLo);
        default: e = 16'd0;
      endcase
      check({16'd0, hostRdData}, {16'd0, e}, hostAddr == 2'd0 ? "R3 model" : "R5 model");
    end
  end

  always @(posedge clk) begin
    #1;
    if (randOn) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      evtInc <= lfsr[EW-1:0];
    end
  end

  task automatic doReset();
    @(posedge clk); #1 rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  // write at one edge, busy cycle, command done; returns 1ns after the done edge
  task automatic cmd(input logic [15:0] d, input bit chkBusy);
    @(posedge clk); #1 hostWr = 1'b1; hostAddr = 2'd0; hostWrData = d;
    @(posedge clk); #1 hostWr = 1'b0;
    if (chkBusy) begin
      @(negedge clk); check({16'd0, hostRdData}, 32'h8000, "R3 busy set");
    end
    @(posedge clk); #1;
    if (chkBusy) begin
      check({16'd0, hostRdData}, 32'h0, "R3 busy clear");
    end
  endtask

  task automatic peek(output logic [31:0] v);
    hostAddr = 2'd1; #0.5 v[31:16] = hostRdData;
    hostAddr = 2'd2; #0.5 v[15:0]  = hostRdData;
    hostAddr = 2'd0;
  endtask

  task automatic readCnt(input int idx, output logic [31:0] v);
    cmd(16'hCC00 | 16'(idx), 0);
    peek(v);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    doReset();
    // R1: reset state of all registers
    for (int a = 0; a < 4; a++) begin
      hostAddr = 2'(a); #0.5 check({16'd0, hostRdData}, 32'h0, "R1 reset reg");
    end
    hostAddr = 2'd0;
    cmd(16'hDC00, 1);
    readCnt(1, v); check(v, 32'h0, "R1 captured zero");

    // R2: wrap modulo 2^W on port 1 counter 2
    @(posedge clk); #1 evtInc[1*C+2] = 1'b1;
    repeat (4100) @(posedge clk);
    #1 evtInc = '0;
    cmd(16'hDC01, 1);
    readCnt(2, v); check(v, 32'd4, "R2 wrap count");
    readCnt(1, v); check(v, 32'd0, "R2 neighbour untouched");

    // R4: increment landing in busy cycle is not captured
    doReset();
    @(posedge clk); #1 hostWr = 1'b1; hostWrData = 16'hDC00;
    @(posedge clk); #1 hostWr = 1'b0; evtInc[0] = 1'b1;
    @(posedge clk); #1 evtInc[0] = 1'b0;
    readCnt(0, v); check(v, 32'd0, "R4 capture excludes busy-cycle inc");
    cmd(16'hDC00, 0);
    readCnt(0, v); check(v, 32'd1, "R4 live kept busy-cycle inc");
    // R4: out-of-range port leaves bank unchanged
    @(posedge clk); #1 evtInc[0] = 1'b1;
    repeat (3) @(posedge clk);
    #1 evtInc = '0;
    cmd(16'hDC07, 1);
    readCnt(0, v); check(v, 32'd1, "R4 bad port keeps bank");
    // R4: whole port captured, counter c gets c+1 events
    for (int i = 0; i <= C - 1; i++) begin
      @(posedge clk); #1;
      for (int c = 0; c < C; c++) evtInc[2*C+c] = (c >= i);
    end
    @(posedge clk); #1 evtInc = '0;
    cmd(16'hDC02, 0);
    for (int c = 0; c < C; c++) begin
      readCnt(c, v); check(v, 32'(c + 1), "R4 port capture");
    end

    // R6: out-of-range index reads zero (data was nonzero)
    readCnt(4, v); check(v, 32'd5, "R5 index 4 value");
    readCnt(5, v); check(v, 32'd0, "R6 index at limit");
    readCnt(3, v);
    readCnt(200, v); check(v, 32'd0, "R6 large index");

    // R8: unknown opcode, data-register writes, write while busy
    readCnt(4, v);
    @(posedge clk); #1 hostWr = 1'b1; hostAddr = 2'd0; hostWrData = 16'hAB03;
    @(posedge clk); #1 hostWr = 1'b0;
    #0.5 check({16'd0, hostRdData}, 32'h0, "R8 bad opcode no busy");
    @(posedge clk); #1 hostWr = 1'b1; hostAddr = 2'd1; hostWrData = 16'hCC01;
    @(posedge clk); #1 hostWr = 1'b0; hostAddr = 2'd0;
    #0.5 check({16'd0, hostRdData}, 32'h0, "R8 data-reg write no busy");
    peek(v); check(v, 32'd5, "R8 data regs unchanged");
    @(posedge clk); #1 hostWr = 1'b1; hostWrData = 16'hDC00;
    @(posedge clk); #1 hostWrData = 16'hCC00;
    @(posedge clk); #1 hostWr = 1'b0;
    #0.5 check({16'd0, hostRdData}, 32'h0, "R8 no busy after ignored cmd");
    peek(v); check(v, 32'd5, "R8 read while busy ignored");

    // R7: frozen bank while live counters run
    randOn = 1;
    repeat (500) @(posedge clk);
    cmd(16'hDC01, 1);
    readCnt(0, v);
    repeat (300) @(posedge clk);
    readCnt(0, v2); check(v2, v, "R7 repeat read stable");
    readCnt(3, v);
    readCnt(4, v2);
    repeat (300) @(posedge clk);
    readCnt(3, v2); check(v2, v, "R7 pair low stable");
    repeat (1000) @(posedge clk);
    randOn = 0;
    @(posedge clk); #1 evtInc = '0;
    repeat (5) @(posedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule